// File: doc/BRIEF.md
# Descending Stack Pointer Unit

This block holds a 16-bit stack pointer and turns stack commands into data-memory accesses. The pointer is loaded by software as two byte-wide halves. It moves downward as data is stored. The memory itself sits outside the block. The block drives an address, a write byte, and a write or read strobe, and it takes the read byte back combinationally in the same cycle.

There are two kinds of access, and they step the pointer by different amounts:

- Single-byte pushes and pops move the pointer by one. A push stores at the current pointer and then steps down. A pop steps up first and then reads.
- Return addresses for calls and interrupt entries take two cycles and move the pointer by two. The low byte of the program counter goes to the higher address, and the high byte follows one below.
- A restore reads the two bytes back in the opposite order. It clears the program-counter bits above the implemented width before it hands the address back.

A sticky flag reports any push or save that would leave the pointer under the stack floor.

Top module: `stkptr_unit`

## Requirements
- R1: After reset:
  - `sp` is 0 and `below_floor` is 0.
  - `mem_we`, `mem_re`, `pop_valid`, `ret_valid` and `busy` are all 0.
- R2: Bus writes load the pointer halves, visible after the clock edge:
  - `wr_hi` loads `wr_data` into `sp[15:8]`; `wr_lo` loads it into `sp[7:0]`.
  - Either half may be written alone.
  - In a cycle with an accepted bus write, every stack command is ignored.
- R3: An accepted push:
  - drives `mem_we`=1 in the same cycle, with `mem_addr`=`sp` and `mem_wdata`=`push_data`;
  - then leaves `sp` one lower, modulo 2^16 (0 becomes 0xFFFF).
- R4: An accepted pop:
  - drives `mem_re`=1 with `mem_addr`=`sp`+1 and raises `sp` by one;
  - in the next cycle holds the byte read in `pop_data`, with `pop_valid`=1 for one cycle.
- R5: A call save takes two cycles:
  - first cycle: writes `ret_addr[7:0]` at `sp`;
  - second cycle: writes the zero-extended `ret_addr[12:8]` at the original `sp`-1, with `busy`=1;
  - `sp` ends two lower.
- R6: A return restore takes two cycles:
  - it reads the high byte at `sp`+1 and then the low byte at `sp`+2, and `sp` ends two higher;
  - one cycle after the second read, `ret_valid`=1 for one cycle;
  - at that point `ret_pc` = {high byte with bits 7:5 forced to 0, low byte}, so `ret_pc[15:13]` is always 0.
- R7: When several commands are raised together, only one is performed, with priority restore > save > pop > push. `mem_we` and `mem_re` are never both 1.
- R8: While `busy` is 1, bus writes and all new commands are ignored. The pointer only completes the access in progress.
- R9: The floor flag:
  - `below_floor` is set after an accepted push taken with `sp` < 0x61, or an accepted save taken with `sp` < 0x62;
  - once set, it stays set until an accepted bus write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_hi | input | 1 | Load high pointer byte from `wr_data` |
| wr_lo | input | 1 | Load low pointer byte from `wr_data` |
| wr_data | input | 8 | Bus write byte |
| push | input | 1 | Push one byte |
| pop | input | 1 | Pop one byte |
| call_save | input | 1 | Save a return address (two cycles) |
| ret_restore | input | 1 | Restore a return address (two cycles) |
| push_data | input | 8 | Byte to push |
| ret_addr | input | 13 | Return address to save |
| mem_rdata | input | 8 | Read byte from data memory (same cycle) |
| sp | output | 16 | Current pointer |
| mem_addr | output | 16 | Data-memory address |
| mem_wdata | output | 8 | Data-memory write byte |
| mem_we | output | 1 | Data-memory write strobe |
| mem_re | output | 1 | Data-memory read strobe |
| pop_data | output | 8 | Popped byte |
| pop_valid | output | 1 | `pop_data` valid |
| ret_pc | output | 16 | Restored return address, upper bits cleared |
| ret_valid | output | 1 | `ret_pc` valid |
| busy | output | 1 | Second cycle of a save or restore |
| below_floor | output | 1 | Sticky stack-floor violation flag |

## Verification
A corrupted pointer shows up at the address of the very next access, so every memory strobe is compared with an independently tracked pointer in the same cycle it fires. A sequencer stuck or skipping its second cycle appears within two cycles, in three ways: a missing or extra write in the scoreboard, a wrong `sp` step, or a `ret_valid` that never arrives. Masking and byte-order faults surface only on restore, so they are caught by returning addresses seeded with set upper bits.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;

  localparam int SP_W   = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_SAVE_HI = 2'd1,
    SQ_LOAD_LO = 2'd2
  } sq_state_t;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_PUSH    = 3'd1,
    OP_POP     = 3'd2,
    OP_SAVE    = 3'd3,
    OP_RESTORE = 3'd4
  } op_t;

  // Move the pointer one step in the given direction, wrapping modulo 2^SP_W.
  function automatic logic [SP_W-1:0] sp_move(input logic [SP_W-1:0] cur,
                                               input logic down);
    return down ? (cur - SP_W'(1)) : (cur + SP_W'(1));
  endfunction

  // True when stepping down by 'need' leaves the pointer under 'floor'.
  function automatic logic under_floor(input logic [SP_W-1:0] cur,
                                       input logic [SP_W-1:0] floor,
                                       input logic [1:0]      need);
    return {1'b0, cur} < ({1'b0, floor} + (SP_W+1)'(need));
  endfunction

  // Keep only the program-counter bits that exist in the high byte.
  function automatic logic [BYTE_W-1:0] hi_mask(input logic [BYTE_W-1:0] b,
                                                input int pcw);
    logic [BYTE_W:0] m;
    m = (9'd1 << (pcw - BYTE_W)) - 9'd1;
    return b & m[BYTE_W-1:0];
  endfunction

  // One command per cycle: restore > save > pop > push.
  function automatic op_t pick_op(input logic push, input logic pop,
                                  input logic save, input logic restore);
    if (restore)   return OP_RESTORE;
    else if (save) return OP_SAVE;
    else if (pop)  return OP_POP;
    else if (push) return OP_PUSH;
    else           return OP_NONE;
  endfunction

endpackage

// File: rtl/stkptr_reg.sv
module stkptr_reg
  import stkptr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_hi,
  input  logic                wr_lo,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                step_en,
  input  logic                step_down,
  output logic [SP_W-1:0]     sp
);

  localparam int HALF = SP_W / 2;

  logic [SP_W-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (wr_hi || wr_lo) begin
      if (wr_hi) sp_q[SP_W-1:HALF] <= wr_data[HALF-1:0];
      if (wr_lo) sp_q[HALF-1:0]    <= wr_data[HALF-1:0];
    end else if (step_en) begin
      sp_q <= sp_move(sp_q, step_down);
    end
  end

  assign sp = sp_q;

endmodule

// File: rtl/stkptr_seq.sv
module stkptr_seq
  import stkptr_pkg::*;
#(
  parameter int PCW = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                push,
  input  logic                pop,
  input  logic                save,
  input  logic                restore,
  input  logic [BYTE_W-1:0]   push_data,
  input  logic [PCW-1:0]      ret_addr,
  input  logic [SP_W-1:0]     sp,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic [SP_W-1:0]     mem_addr,
  output logic [BYTE_W-1:0]   mem_wdata,
  output logic                mem_we,
  output logic                mem_re,
  output logic                step_en,
  output logic                step_down,
  output logic [BYTE_W-1:0]   pop_data,
  output logic                pop_valid,
  output logic [SP_W-1:0]     ret_pc,
  output logic                ret_valid,
  output logic                busy,
  output logic                ev_push,
  output logic                ev_pop,
  output logic                ev_save,
  output logic                ev_restore
);

  sq_state_t         state_q, state_d;
  op_t               op;
  logic [BYTE_W-1:0] hold_q;
  logic [SP_W-1:0]   ra_ext;
  logic [SP_W-1:0]   sp_up;

  assign ra_ext = SP_W'(ret_addr);
  assign sp_up  = sp_move(sp, 1'b0);
  assign busy   = (state_q != SQ_IDLE);
  assign op     = (busy || bus_wr) ? OP_NONE : pick_op(push, pop, save, restore);

  assign ev_push    = (op == OP_PUSH);
  assign ev_pop     = (op == OP_POP);
  assign ev_save    = (op == OP_SAVE);
  assign ev_restore = (op == OP_RESTORE);

  always_comb begin
    state_d   = state_q;
    mem_addr  = sp;
    mem_wdata = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    step_en   = 1'b0;
    step_down = 1'b0;
    unique case (state_q)
      SQ_SAVE_HI: begin
        mem_wdata = hold_q;
        mem_we    = 1'b1;
        step_en   = 1'b1;
        step_down = 1'b1;
        state_d   = SQ_IDLE;
      end
      SQ_LOAD_LO: begin
        mem_addr = sp_up;
        mem_re   = 1'b1;
        step_en  = 1'b1;
        state_d  = SQ_IDLE;
      end
      default: begin
        unique case (op)
          OP_PUSH: begin
            mem_wdata = push_data;
            mem_we    = 1'b1;
            step_en   = 1'b1;
            step_down = 1'b1;
          end
          OP_POP: begin
            mem_addr = sp_up;
            mem_re   = 1'b1;
            step_en  = 1'b1;
          end
          OP_SAVE: begin
            mem_wdata = ra_ext[BYTE_W-1:0];
            mem_we    = 1'b1;
            step_en   = 1'b1;
            step_down = 1'b1;
            state_d   = SQ_SAVE_HI;
          end
          OP_RESTORE: begin
            mem_addr = sp_up;
            mem_re   = 1'b1;
            step_en  = 1'b1;
            state_d  = SQ_LOAD_LO;
          end
          default: ;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      hold_q    <= '0;
      pop_data  <= '0;
      pop_valid <= 1'b0;
      ret_pc    <= '0;
      ret_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      pop_valid <= ev_pop;
      ret_valid <= (state_q == SQ_LOAD_LO);
      if (ev_pop)     pop_data <= mem_rdata;
      if (ev_save)    hold_q   <= ra_ext[2*BYTE_W-1:BYTE_W];
      if (ev_restore) hold_q   <= hi_mask(mem_rdata, PCW);
      if (state_q == SQ_LOAD_LO) ret_pc <= {hold_q, mem_rdata};
    end
  end

endmodule

// File: rtl/stkptr_floor.sv
module stkptr_floor
  import stkptr_pkg::*;
#(
  parameter logic [SP_W-1:0] FLOOR = 16'h0060
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SP_W-1:0] sp,
  input  logic            ev_push,
  input  logic            ev_save,
  input  logic            clr,
  output logic            flag
);

  logic hit;

  assign hit = (ev_push && under_floor(sp, FLOOR, 2'd1)) ||
               (ev_save && under_floor(sp, FLOOR, 2'd2));

  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (clr) flag <= 1'b0;
    else if (hit) flag <= 1'b1;
  end

endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit
  import stkptr_pkg::*;
#(
  parameter int               PCW   = 13,
  parameter logic [SP_W-1:0]  FLOOR = 16'h0060
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [7:0]        wr_data,
  input  logic              push,
  input  logic              pop,
  input  logic              call_save,
  input  logic              ret_restore,
  input  logic [7:0]        push_data,
  input  logic [PCW-1:0]    ret_addr,
  input  logic [7:0]        mem_rdata,
  output logic [15:0]       sp,
  output logic [15:0]       mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [7:0]        pop_data,
  output logic              pop_valid,
  output logic [15:0]       ret_pc,
  output logic              ret_valid,
  output logic              busy,
  output logic              below_floor
);

  logic wr_hi_ok, wr_lo_ok, bus_wr_ok;
  logic step_en, step_down;
  logic ev_push, ev_pop, ev_save, ev_restore;

  assign wr_hi_ok  = wr_hi && !busy;
  assign wr_lo_ok  = wr_lo && !busy;
  assign bus_wr_ok = wr_hi_ok || wr_lo_ok;

  stkptr_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hi     (wr_hi_ok),
    .wr_lo     (wr_lo_ok),
    .wr_data   (wr_data),
    .step_en   (step_en),
    .step_down (step_down),
    .sp        (sp)
  );

  stkptr_seq #(.PCW(PCW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr_ok),
    .push       (push),
    .pop        (pop),
    .save       (call_save),
    .restore    (ret_restore),
    .push_data  (push_data),
    .ret_addr   (ret_addr),
    .sp         (sp),
    .mem_rdata  (mem_rdata),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .step_en    (step_en),
    .step_down  (step_down),
    .pop_data   (pop_data),
    .pop_valid  (pop_valid),
    .ret_pc     (ret_pc),
    .ret_valid  (ret_valid),
    .busy       (busy),
    .ev_push    (ev_push),
    .ev_pop     (ev_pop),
    .ev_save    (ev_save),
    .ev_restore (ev_restore)
  );

  stkptr_floor #(.FLOOR(FLOOR)) u_floor (
    .clk     (clk),
    .rst_n   (rst_n),
    .sp      (sp),
    .ev_push (ev_push),
    .ev_save (ev_save),
    .clr     (bus_wr_ok),
    .flag    (below_floor)
  );

endmodule

// File: rtl/stkptr_unit_chk.sv
module stkptr_unit_chk #(
  parameter int PCW = 13
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] sp,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] ret_pc,
  input logic        ret_valid,
  input logic        busy,
  input logic        wr_hi,
  input logic        wr_lo,
  input logic        ev_push,
  input logic        ev_save,
  input logic        ev_restore,
  input logic        bus_wr_ok,
  input logic        below_floor
);

  AST_PUSH_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |=> (sp == $past(sp) - 16'd1)); // R3

  AST_SAVE_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_save |=> busy ##1 (sp == $past(sp, 2) - 16'd2)); // R5

  AST_RESTORE_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_restore |=> ##1 (ret_valid && sp == $past(sp, 2) + 16'd2)); // R6

  AST_PC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> (ret_pc[15:PCW] == '0)); // R6

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R7

  AST_BUSY_IGNORES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (wr_hi || wr_lo)) |=> (sp == $past(sp) - 16'd1 || sp == $past(sp) + 16'd1)); // R8

  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_ok |=> !below_floor); // R9

endmodule

bind stkptr_unit stkptr_unit_chk #(.PCW(PCW)) u_chk (.*);

// File: tb/sim_stkptr_unit.sv
`timescale 1ns/1ps
module sim_stkptr_unit;

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  data;
  } wr_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_hi = 0, wr_lo = 0, push = 0, pop = 0, call_save = 0, ret_restore = 0;
  logic [7:0]  wr_data = 0, push_data = 0;
  logic [12:0] ret_addr = 0;
  logic [7:0]  mem_rdata;
  logic [15:0] sp, mem_addr, ret_pc;
  logic [7:0]  mem_wdata, pop_data;
  logic        mem_we, mem_re, pop_valid, ret_valid, busy, below_floor;

  logic [7:0]  mem [0:255];
  wr_item_t    expq[$];
  logic [15:0] sp_m;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  stkptr_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .push(push), .pop(pop), .call_save(call_save), .ret_restore(ret_restore),
    .push_data(push_data), .ret_addr(ret_addr), .mem_rdata(mem_rdata),
    .sp(sp), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .pop_data(pop_data), .pop_valid(pop_valid),
    .ret_pc(ret_pc), .ret_valid(ret_valid), .busy(busy), .below_floor(below_floor)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Scoreboard monitor: every write strobe must match the next expected item.
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (expq.size() == 0) chk(0, "R3 R5 R7 unexpected write", {mem_addr, mem_wdata}, 0);
      else begin
        wr_item_t e;
        e = expq.pop_front();
        chk({mem_addr, mem_wdata} == {e.addr, e.data}, "R3 R5 write", {mem_addr, mem_wdata}, {e.addr, e.data});
      end
    end
  end

  task automatic step();
    @(posedge clk); #2;
    wr_hi = 0; wr_lo = 0; push = 0; pop = 0; call_save = 0; ret_restore = 0;
  endtask

  task automatic set_sp(input logic [15:0] v);
    @(posedge clk); #2; wr_hi = 1; wr_data = v[15:8];
    @(posedge clk); #2; wr_hi = 0; wr_lo = 1; wr_data = v[7:0];
    step();
    sp_m = v;
    @(negedge clk);
    chk(sp == v, "R2 pointer load", sp, v);
  endtask

  task automatic do_push(input logic [7:0] d);
    @(posedge clk); #2; push = 1; push_data = d;
    expq.push_back('{sp_m, d});
    step();
    sp_m = sp_m - 1;
    @(negedge clk);
    chk(sp == sp_m, "R3 push step", sp, sp_m);
  endtask

  task automatic do_pop(input logic [7:0] d);
    @(posedge clk); #2; pop = 1;
    @(negedge clk);
    chk(mem_re && mem_addr == sp_m + 16'd1, "R4 pop address", mem_addr, sp_m + 16'd1);
    step();
    sp_m = sp_m + 1;
    @(negedge clk);
    chk(pop_valid && pop_data == d, "R4 pop data", {pop_valid, pop_data}, {1'b1, d});
    chk(sp == sp_m, "R4 pop step", sp, sp_m);
  endtask

  task automatic do_call(input logic [12:0] ra);
    @(posedge clk); #2; call_save = 1; ret_addr = ra;
    expq.push_back('{sp_m, ra[7:0]});
    expq.push_back('{sp_m - 16'd1, {3'b000, ra[12:8]}});
    step();
    @(negedge clk);
    chk(busy, "R5 busy in second cycle", busy, 1);
    step();
    sp_m = sp_m - 2;
    @(negedge clk);
    chk(sp == sp_m && !busy, "R5 save step", sp, sp_m);
  endtask

  task automatic do_ret(input logic [15:0] pc);
    @(posedge clk); #2; ret_restore = 1;
    @(negedge clk);
    chk(mem_re && mem_addr == sp_m + 16'd1, "R6 first read", mem_addr, sp_m + 16'd1);
    step();
    @(negedge clk);
    chk(mem_re && mem_addr == sp_m + 16'd2, "R6 second read", mem_addr, sp_m + 16'd2);
    step();
    sp_m = sp_m + 2;
    @(negedge clk);
    chk(ret_valid && ret_pc == pc, "R6 restored address", ret_pc, pc);
    chk(sp == sp_m, "R6 restore step", sp, sp_m);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    sp_m = 16'h0000;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(sp == 0 && !below_floor, "R1 reset pointer/flag", {sp, below_floor}, 0);
    chk(!mem_we && !mem_re && !pop_valid && !ret_valid && !busy, "R1 reset strobes",
        {mem_we, mem_re, pop_valid, ret_valid, busy}, 0);

    // Wrap from zero, which also trips the floor flag.
    do_push(8'h77);
    chk(sp == 16'hFFFF, "R3 wrap", sp, 16'hFFFF);
    chk(below_floor, "R9 flag on push under floor", below_floor, 1);

    set_sp(16'h0180);
    chk(!below_floor, "R9 flag cleared by write", below_floor, 0);

    do_push(8'hA5);
    do_push(8'h3C);
    do_pop(8'h3C);
    do_pop(8'hA5);

    do_call(13'h1ABC);
    do_ret(16'h1ABC);

    // Masking of stored high byte with spare bits set.
    set_sp(16'h017E);
    mem[8'h7F] = 8'hFF; mem[8'h80] = 8'h34;
    do_ret(16'h1F34);

    // Push and pop together: pop wins, no write.
    do_push(8'h55);
    @(posedge clk); #2; push = 1; pop = 1; push_data = 8'h99;
    @(negedge clk);
    chk(mem_re && !mem_we, "R7 pop beats push", {mem_re, mem_we}, 2'b10);
    step();
    sp_m = sp_m + 1;
    @(negedge clk);
    chk(pop_data == 8'h55 && sp == sp_m, "R7 pop result", {sp, pop_data}, {sp_m, 8'h55});

    // Restore and save together: restore wins.
    mem[8'h81] = 8'h05; mem[8'h82] = 8'h66;
    @(posedge clk); #2; call_save = 1; ret_restore = 1; ret_addr = 13'h0AAA;
    @(negedge clk);
    chk(mem_re && !mem_we, "R7 restore beats save", {mem_re, mem_we}, 2'b10);
    step();
    step();
    sp_m = sp_m + 2;
    @(negedge clk);
    chk(ret_valid && ret_pc == 16'h0566 && sp == sp_m, "R7 restore result", ret_pc, 16'h0566);

    // Commands and bus writes during busy are ignored.
    @(posedge clk); #2; call_save = 1; ret_addr = 13'h0123;
    expq.push_back('{sp_m, 8'h23});
    expq.push_back('{sp_m - 16'd1, 8'h01});
    @(posedge clk); #2; call_save = 0; wr_lo = 1; wr_data = 8'h00; push = 1; push_data = 8'hEE;
    step();
    sp_m = sp_m - 2;
    @(negedge clk);
    chk(sp == sp_m, "R8 busy ignores write and push", sp, sp_m);

    // Floor flag boundaries.
    set_sp(16'h0061);
    do_push(8'h11);
    chk(!below_floor, "R9 push at 0x61 no flag", below_floor, 0);
    do_push(8'h22);
    chk(below_floor, "R9 push at 0x60 flags", below_floor, 1);
    do_push(8'h33);
    chk(below_floor, "R9 flag sticky", below_floor, 1);
    set_sp(16'h0063);
    chk(!below_floor, "R9 cleared", below_floor, 0);
    do_call(13'h0456);
    chk(!below_floor, "R9 save at 0x63 no flag", below_floor, 0);
    do_call(13'h0789);
    chk(below_floor, "R9 save at 0x61 flags", below_floor, 1);

    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R3 R5 all writes seen", expq.size(), 0);
    report();
  end

endmodule